// File: doc/BRIEF.md
# Echo-Confirmed ASCII Command Sender

This block drives one fixed ASCII command into a controller. The controller pulls the command in through a byte-source buffer interface. A `start` pulse makes the first character available: `src_empty` goes low and the character appears on `src_data`. Each time the controller pulses `src_read`, the next character takes its place. After the last character has been read, `src_empty` returns high. The command string is a parameter of up to 16 bytes, and its length is a second parameter.

A controller that accepts a command writes the same characters back. The block acts as the sink for that echo. It never raises `echo_full`, so the echo is never stalled. Each returned byte is checked against the byte sent at the same position. The handshake finishes only after the whole string has come back byte-for-byte, which is signalled by a one-cycle `done` pulse. The block can accept the next `start` only after the handshake finishes or is aborted.

Two conditions abort the handshake. A wrong byte gives a one-cycle `err_mismatch` pulse. An echo that is not complete within a fixed number of cycles gives a one-cycle `err_timeout` pulse. In both cases the block withdraws any bytes still unread and returns to idle.

Top module: `cmd_echo_sender`

## Requirements
- R1: After reset, `src_empty` is 1 and `done`, `err_mismatch` and `err_timeout` are 0.
- R2: A `start` pulse while idle makes `src_empty` 0 in the next cycle, with byte 0 of the command on `src_data`. With the default command this is 0x4E ('N').
- R3: Byte i of the command is bits [8i+7:8i] of `CMD_ROM`. The default command is `N C0000007A4`, sent in string order. Each `src_read` sampled while `src_empty` is 0 moves `src_data` to the next byte in the next cycle. Without a read, `src_data` holds its value.
- R4: `src_empty` returns to 1 in the cycle after the final byte is read. Apart from that, it rises only when the handshake ends.
- R5: A `src_read` while `src_empty` is 1 has no effect: `src_empty` stays 1 and no pulse is produced.
- R6: A `start` pulse while a command is in progress is ignored, and the byte on `src_data` is unchanged.
- R7: Echo bytes are compared in order against the sent bytes. `done` pulses for exactly one cycle, in the cycle after the final echo byte matches. The block is then idle.
- R8: The first echo byte that differs raises `err_mismatch` for one cycle in the next cycle. The handshake is aborted: `src_empty` is 1 and no `done` follows. A later `start` is accepted.
- R9: If the echo is not complete at the `TIMEOUT_CYCLES`-th clock edge after the `start` edge, `err_timeout` pulses for one cycle in the next cycle. The handshake is aborted and `src_empty` is 1.
- R10: `echo_full` is always 0, and an `echo_write` while idle produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin sending the command (honoured only while idle) |
| src_data | output | 8 | Current command byte offered to the controller |
| src_empty | output | 1 | High when no byte is offered |
| src_read | input | 1 | Controller consumes the offered byte |
| echo_data | input | 8 | Byte returned by the controller |
| echo_write | input | 1 | `echo_data` is valid this cycle |
| echo_full | output | 1 | Echo sink full flag, held low |
| done | output | 1 | One-cycle pulse: full echo matched |
| err_mismatch | output | 1 | One-cycle pulse: echo byte differed |
| err_timeout | output | 1 | One-cycle pulse: echo not complete in time |

## Verification
The properties take `rst_n` as the only framing of history. They assume that `start`, `src_read` and `echo_write` are synchronous to `clk`. The data-hold property assumes the controller may sample `src_data` in any cycle where `src_empty` is low and it does not read.

The stimulus reads only while `src_empty` is low, except for a deliberate probe of reads while empty. It writes echo bytes back to back, one per cycle. The mismatch case is swept over every position of the default command. The timeout cases keep the handshake short enough that only the deliberately truncated echoes can expire.

// File: rtl/cmd_echo_sender.sv
module cmd_echo_sender #(
  parameter int          CMD_LEN        = 12,
  parameter logic [127:0] CMD_ROM       = 128'h00000000_34413730_30303030_3043204E,
  parameter int          TIMEOUT_CYCLES = 4096
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  output logic [7:0] src_data,
  output logic       src_empty,
  input  logic       src_read,
  input  logic [7:0] echo_data,
  input  logic       echo_write,
  output logic       echo_full,
  output logic       done,
  output logic       err_mismatch,
  output logic       err_timeout
);
  localparam int IW = 4;
  localparam int CW = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [IW-1:0] LAST = IW'(CMD_LEN - 1);
  localparam logic [CW-1:0] TMAX = CW'(TIMEOUT_CYCLES - 1);

  logic          busy;
  logic [IW-1:0] tx_idx, rx_idx;
  logic [CW-1:0] tmo_cnt;
  logic          empty_q;
  logic          echo_hit, echo_ok, finish, mism, tmo;

  function automatic logic [7:0] rom_byte(input logic [IW-1:0] idx);
    return CMD_ROM[8*idx +: 8];
  endfunction

  assign src_data  = rom_byte(tx_idx);
  assign src_empty = empty_q;
  assign echo_full = 1'b0;

  assign echo_hit = busy && echo_write;
  assign echo_ok  = echo_data == rom_byte(rx_idx);
  assign finish   = echo_hit && echo_ok && (rx_idx == LAST);
  assign mism     = echo_hit && !echo_ok;
  assign tmo      = busy && (tmo_cnt == TMAX) && !finish && !mism;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy         <= 1'b0;
      empty_q      <= 1'b1;
      tx_idx       <= '0;
      rx_idx       <= '0;
      tmo_cnt      <= '0;
      done         <= 1'b0;
      err_mismatch <= 1'b0;
      err_timeout  <= 1'b0;
    end else begin
      done         <= finish;
      err_mismatch <= mism;
      err_timeout  <= tmo;
      if (!busy) begin
        if (start) begin
          busy    <= 1'b1;
          empty_q <= 1'b0;
          tx_idx  <= '0;
          rx_idx  <= '0;
          tmo_cnt <= '0;
        end
      end else if (finish || mism || tmo) begin
        busy    <= 1'b0;
        empty_q <= 1'b1;
      end else begin
        tmo_cnt <= tmo_cnt + 1'b1;
        if (echo_hit) rx_idx <= rx_idx + 1'b1;
        if (!empty_q && src_read) begin
          if (tx_idx == LAST) empty_q <= 1'b1;
          else                tx_idx  <= tx_idx + 1'b1;
        end
      end
    end
  end

  a_r1_outputs_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, err_mismatch, err_timeout}));

  a_r3_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_empty && !src_read) |=> $stable(src_data));

  a_r4_empty_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(src_empty) |-> ($past(src_read) || done || err_mismatch || err_timeout));

  a_r7_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(echo_write));

  a_r8_mismatch_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    err_mismatch |-> ($past(echo_write) && src_empty));

  a_r9_timeout_idles: assert property (@(posedge clk) disable iff (!rst_n)
    err_timeout |-> (!busy && src_empty && $past(busy)));

  a_r10_no_pulse_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(busy) |-> !(done || err_mismatch || err_timeout));
endmodule

// File: tb/test_cmd_echo_sender.sv
module test_cmd_echo_sender;
  localparam int LEN = 12;
  localparam int T   = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] src_data;
  logic       src_empty;
  logic       src_read = 1'b0;
  logic [7:0] echo_data = 8'h00;
  logic       echo_write = 1'b0;
  logic       echo_full, done, err_mismatch, err_timeout;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  string cmd = "N C0000007A4";

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cmd_echo_sender #(.CMD_LEN(LEN), .TIMEOUT_CYCLES(T)) i_cmd_echo_sender (
    .clk(clk), .rst_n(rst_n), .start(start), .src_data(src_data),
    .src_empty(src_empty), .src_read(src_read), .echo_data(echo_data),
    .echo_write(echo_write), .echo_full(echo_full), .done(done),
    .err_mismatch(err_mismatch), .err_timeout(err_timeout));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic do_start;
    start = 1'b1;
    tick();
    start = 1'b0;
  endtask

  task automatic read_range(input int first, input int last);
    for (int i = first; i <= last; i++) begin
      chk(i == 0 ? "R2 empty" : "R3 empty", src_empty, 0);
      chk(i == 0 ? "R2 first byte" : "R3 byte order", src_data, cmd[i]);
      src_read = 1'b1;
      tick();
    end
    src_read = 1'b0;
  endtask

  task automatic echo_all(input int bad);
    for (int i = 0; i < LEN; i++) begin
      echo_write = 1'b1;
      echo_data  = (i == bad) ? (cmd[i] ^ 8'h01) : cmd[i];
      tick();
      chk("R10 full low", echo_full, 0);
      if (i == bad) begin
        echo_write = 1'b0;
        chk("R8 mismatch pulse", err_mismatch, 1);
        chk("R8 no done", done, 0);
        chk("R8 aborted", src_empty, 1);
        tick();
        chk("R8 pulse width", err_mismatch, 0);
        break;
      end else if (i == LEN - 1) begin
        echo_write = 1'b0;
        chk("R7 done", done, 1);
        tick();
        chk("R7 done width", done, 0);
      end else begin
        chk("R7 no early done", {done, err_mismatch}, 0);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int s;
    tick(); tick();
    rst_n = 1'b1;
    tick();
    chk("R1 empty", src_empty, 1);
    chk("R1 pulses", {done, err_mismatch, err_timeout}, 0);

    echo_write = 1'b1; echo_data = cmd[0];
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R10 idle echo", {done, err_mismatch, err_timeout}, 0);
      chk("R10 full low", echo_full, 0);
    end
    echo_write = 1'b0;

    do_start();
    read_range(0, LEN - 1);
    chk("R4 empty after last", src_empty, 1);
    src_read = 1'b1;
    tick(); tick();
    src_read = 1'b0;
    chk("R5 read while empty", src_empty, 1);
    chk("R5 no pulse", {done, err_mismatch, err_timeout}, 0);
    echo_all(-1);

    do_start();
    read_range(0, 3);
    start = 1'b1;
    tick();
    start = 1'b0;
    chk("R6 start ignored empty", src_empty, 0);
    chk("R6 start ignored byte", src_data, cmd[4]);
    read_range(4, LEN - 1);
    chk("R4 empty after last", src_empty, 1);
    echo_all(-1);

    for (int p = 0; p < LEN; p++) begin
      do_start();
      read_range(0, LEN - 1);
      echo_all(p);
      chk("R8 stays idle", {done, src_empty}, 1);
    end

    start = 1'b1; s = cyc;
    tick();
    start = 1'b0;
    chk("R9 offered", src_empty, 0);
    while (cyc < s + T) tick();
    chk("R9 not early", err_timeout, 0);
    chk("R9 still offered", src_empty, 0);
    tick();
    chk("R9 timeout pulse", err_timeout, 1);
    chk("R9 withdrawn", src_empty, 1);
    tick();
    chk("R9 pulse width", err_timeout, 0);

    start = 1'b1; s = cyc;
    tick();
    start = 1'b0;
    read_range(0, LEN - 1);
    for (int i = 0; i < 5; i++) begin
      echo_write = 1'b1; echo_data = cmd[i];
      tick();
    end
    echo_write = 1'b0;
    while (cyc < s + T) tick();
    chk("R9 not early partial", {done, err_timeout}, 0);
    tick();
    chk("R9 timeout partial", err_timeout, 1);
    chk("R9 no done", done, 0);

    do_start();
    read_range(0, LEN - 1);
    echo_all(-1);

    tick();
    summary();
  end
endmodule